// File: doc/BRIEF.md
# Paged GPIO Register Block

This block is the host-facing register file of a 48-line bidirectional digital I/O controller. A simple synchronous host bus (address, write data, read/write strobes, registered read data) reaches an 11-byte window. Six byte-wide data ports drive the open-collector line outputs and return the live pin levels. A page/lock register picks which of three banks (edge polarity, interrupt enable, or pending status) shows through the three addresses at the top of the window.

The lower 24 lines (ports 0 to 2) can raise interrupts. The block hands per-line enable and polarity vectors to a separate edge-detection unit. It reads that unit's pending vector back and emits a one-cycle clear pulse for the bits the host writes on the status page. The bus sequencing and the edge detection are outside this block.

Top module: `paged_gpio_regs`

## Requirements
- R1: After reset, all 48 drive outputs are 0, all enable and polarity bits are 0, the clear pulse is 0, read data is 0x00 and the page/lock register reads 0x00.
- R2: A write to offset p (0 to 5) loads the drive byte of port p, so line n follows bit n%8 of the byte written to offset n/8. Other ports keep their value, and drive outputs change only on a write.
- R3: A read of offset p (0 to 5) returns the pin input levels of lines 8p to 8p+7, bit i being line 8p+i.
- R4: Offset 0x7 holds the full byte last written and reads it back. Its bits 7:6 form the page field.
- R5: With page field 1, offset 0x8+k (k = 0 to 2) reads and writes the polarity byte of port k.
- R6: With page field 2, offset 0x8+k reads and writes the enable byte of port k. Enable and polarity change only on a matching write.
- R7: With page field 3, offset 0x8+k reads the pending inputs of port k. A write there pulses the clear output of port k with the written byte for exactly one cycle and changes neither enable nor polarity.
- R8: With page field 0, writes to 0x8 to 0xA have no effect on enable, polarity or clear, and reads there return 0x00.
- R9: Offset 0x6 and offsets 0xB to 0xF read 0x00, and writes to them change no output.
- R10: Read data is registered. It takes the addressed value on the clock edge where the read strobe is high and holds it while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pin_i | input | 48 | Sampled line levels |
| drive_o | output | 48 | Line drive, 1 pulls the line, 0 releases it |
| irq_pend_i | input | 24 | Pending flags from the edge detector |
| irq_en_o | output | 24 | Per-line interrupt enable |
| irq_pol_o | output | 24 | Per-line edge polarity, 1 selects rising |
| irq_clr_o | output | 24 | One-cycle pending-clear pulse |

## Verification
Every data port is written with an arithmetic pattern that differs per port, and single lines are walked, so a swapped port or bit shows as a mismatch across the whole 48-bit drive vector. Pin levels are read back under three patterns per port to expose slice or ordering errors. All four page values are swept over all three banked offsets, and each write is checked against all three side-band vectors, so a page decoded to the wrong bank is caught. Every other offset, including the reserved one and those above the window, is read and written to confirm it reads zero and has no effect.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_data_bank.sv
module gpio_data_bank #(
  parameter int NUM_PORTS = 6,
  parameter int DW        = 8,
  parameter int AW        = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NUM_PORTS*DW-1:0] drive_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (wr_i && addr_i == AW'(p))     q <= wdata_i;
    end
    assign drive_o[p*DW +: DW] = q;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_regs_pkg::*;
#(
  parameter int IRQ_PORTS = 3,
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int BANK_BASE = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  page_e                   page_i,
  output logic [IRQ_PORTS*DW-1:0] en_o,
  output logic [IRQ_PORTS*DW-1:0] pol_o,
  output logic [IRQ_PORTS*DW-1:0] clr_o
);
  for (genvar k = 0; k < IRQ_PORTS; k++) begin : g_bank
    logic          hit;
    logic [DW-1:0] en_q, pol_q, clr_q;
    assign hit = wr_i && (addr_i == AW'(BANK_BASE + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= '0;
        pol_q <= '0;
        clr_q <= '0;
      end else begin
        if (hit && page_i == PG_EN)  en_q  <= wdata_i;
        if (hit && page_i == PG_POL) pol_q <= wdata_i;
        // status page write acknowledges pending bits for one cycle
        clr_q <= (hit && page_i == PG_ID) ? wdata_i : '0;
      end
    end
    assign en_o[k*DW +: DW]  = en_q;
    assign pol_o[k*DW +: DW] = pol_q;
    assign clr_o[k*DW +: DW] = clr_q;
  end
endmodule

// File: rtl/paged_gpio_regs.sv
module paged_gpio_regs
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3,
  parameter int DW        = 8,
  parameter int AW        = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  output logic [DW-1:0]           rdata_o,
  input  logic [NUM_PORTS*DW-1:0] pin_i,
  output logic [NUM_PORTS*DW-1:0] drive_o,
  input  logic [IRQ_PORTS*DW-1:0] irq_pend_i,
  output logic [IRQ_PORTS*DW-1:0] irq_en_o,
  output logic [IRQ_PORTS*DW-1:0] irq_pol_o,
  output logic [IRQ_PORTS*DW-1:0] irq_clr_o
);
  localparam int PAGE_ADDR = NUM_PORTS + 1;
  localparam int BANK_BASE = NUM_PORTS + 2;

  logic [DW-1:0] page_q, rd_mux, rdata_q;
  page_e         page;

  assign page = page_e'(page_q[DW-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                page_q <= '0;
    else if (wr_i && addr_i == AW'(PAGE_ADDR))  page_q <= wdata_i;
  end

  gpio_data_bank #(.NUM_PORTS(NUM_PORTS), .DW(DW), .AW(AW)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .drive_o (drive_o)
  );

  gpio_irq_bank #(.IRQ_PORTS(IRQ_PORTS), .DW(DW), .AW(AW), .BANK_BASE(BANK_BASE)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .page_i  (page),
    .en_o    (irq_en_o),
    .pol_o   (irq_pol_o),
    .clr_o   (irq_clr_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr_i == AW'(p)) rd_mux = pin_i[p*DW +: DW];
    if (addr_i == AW'(PAGE_ADDR)) rd_mux = page_q;
    for (int k = 0; k < IRQ_PORTS; k++) begin
      if (addr_i == AW'(BANK_BASE + k)) begin
        unique case (page)
          PG_POL:  rd_mux = irq_pol_o[k*DW +: DW];
          PG_EN:   rd_mux = irq_en_o[k*DW +: DW];
          PG_ID:   rd_mux = irq_pend_i[k*DW +: DW];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int NL = 48,
  parameter int IL = 24,
  parameter int RSV_ADDR = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    page_i,
  input logic [NL-1:0] drive_o,
  input logic [IL-1:0] en_o,
  input logic [IL-1:0] pol_o,
  input logic [IL-1:0] clr_o,
  input logic [DW-1:0] rdata_o
);
  assert_drive_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(drive_o));

  assert_side_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o) && $stable(pol_o));

  assert_clr_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> $past(wr_i) && $past(page_i) == 2'd3);

  assert_page0_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && page_i == 2'd0) |=> $stable(en_o) && $stable(pol_o) && clr_o == '0);

  assert_reserved_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(RSV_ADDR)) |=> $stable(drive_o) && $stable(en_o) && $stable(pol_o));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind paged_gpio_regs gpio_regs_chk #(
  .AW(AW), .DW(DW), .NL(NUM_PORTS*DW), .IL(IRQ_PORTS*DW), .RSV_ADDR(NUM_PORTS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .page_i  (page_q[DW-1 -: 2]),
  .drive_o (drive_o),
  .en_o    (irq_en_o),
  .pol_o   (irq_pol_o),
  .clr_o   (irq_clr_o),
  .rdata_o (rdata_o)
);

// File: tb/sim_paged_gpio_regs.sv
module sim_paged_gpio_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_ni = 0, wr = 0, rd = 0;
  logic [3:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [47:0] pin = 0, drive;
  logic [23:0] pend = 0, en, pol, clr;
  int n_run = 0, n_fail = 0;
  logic done = 0;

  logic [47:0] m_drive = 0;
  logic [23:0] m_en = 0, m_pol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_gpio_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .pin_i(pin), .drive_o(drive), .irq_pend_i(pend),
    .irq_en_o(en), .irq_pol_o(pol), .irq_clr_o(clr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1; wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(posedge clk); #1; rd = 0; d = rdata;
  endtask

  task automatic chk_side(input string req);
    chk(req, {16'h0, drive}, {16'h0, m_drive});
    chk(req, {40'h0, en}, {40'h0, m_en});
    chk(req, {40'h0, pol}, {40'h0, m_pol});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state, checked before release
    chk("R1 drive", {16'h0, drive}, 64'h0);
    chk("R1 en", {40'h0, en}, 64'h0);
    chk("R1 pol", {40'h0, pol}, 64'h0);
    chk("R1 clr", {40'h0, clr}, 64'h0);
    chk("R1 rdata", {56'h0, rdata}, 64'h0);
    rst_ni = 1;
    rd_reg(4'h7, d); chk("R1 page", {56'h0, d}, 64'h0);

    // R2 per-port patterns
    for (int p = 0; p < 6; p++) begin
      logic [7:0] v;
      v = 8'hA5 ^ 8'(p * 17);
      wr_reg(4'(p), v);
      m_drive[p*8 +: 8] = v;
      chk($sformatf("R2 port %0d", p), {16'h0, drive}, {16'h0, m_drive});
    end
    // R2 walking single line
    for (int n = 0; n < 48; n += 5) begin
      logic [7:0] v;
      v = 8'(1 << (n % 8));
      wr_reg(4'(n / 8), v);
      m_drive[(n/8)*8 +: 8] = v;
      chk($sformatf("R2 line %0d", n), {63'h0, drive[n]}, 64'h1);
      chk("R2 vector", {16'h0, drive}, {16'h0, m_drive});
    end

    // R3 pin readback, three patterns per port
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 6; p++) pin[p*8 +: 8] = 8'((p + 1) * (37 + s * 29));
      for (int p = 0; p < 6; p++) begin
        rd_reg(4'(p), d);
        chk($sformatf("R3 port %0d pat %0d", p, s), {56'h0, d}, {56'h0, 8'((p + 1) * (37 + s * 29))});
      end
    end

    // R10 hold while strobe low
    rd_reg(4'h2, d);
    pin = ~pin;
    @(negedge clk); @(negedge clk);
    chk("R10 hold", {56'h0, rdata}, {56'h0, d});

    // R9 reserved and out-of-window offsets
    for (int a = 6; a < 16; a++) begin
      if (a >= 7 && a <= 10) continue;
      wr_reg(4'(a), 8'hFF);
      chk_side($sformatf("R9 write %0h", a));
      rd_reg(4'(a), d);
      chk($sformatf("R9 read %0h", a), {56'h0, d}, 64'h0);
    end

    // R4 page register full byte
    wr_reg(4'h7, 8'h3C);
    rd_reg(4'h7, d); chk("R4 readback", {56'h0, d}, 64'h3C);

    // R8 page 0 ignores bank
    pend = 24'h5A_C3_81;
    for (int k = 0; k < 3; k++) begin
      wr_reg(4'(8 + k), 8'hFF);
      chk("R8 clr", {40'h0, clr}, 64'h0);
      chk_side("R8 side");
      rd_reg(4'(8 + k), d);
      chk("R8 read", {56'h0, d}, 64'h0);
    end

    // R5 polarity page
    wr_reg(4'h7, 8'h40);
    for (int k = 0; k < 3; k++) begin
      wr_reg(4'(8 + k), 8'(8'h1E + k * 71));
      m_pol[k*8 +: 8] = 8'(8'h1E + k * 71);
      chk("R5 pol", {40'h0, pol}, {40'h0, m_pol});
      chk("R5 clr", {40'h0, clr}, 64'h0);
    end
    for (int k = 0; k < 3; k++) begin
      rd_reg(4'(8 + k), d);
      chk("R5 read", {56'h0, d}, {56'h0, m_pol[k*8 +: 8]});
    end

    // R6 enable page, low bits of page reg are don't-care
    wr_reg(4'h7, 8'h95);
    rd_reg(4'h7, d); chk("R4 readback 2", {56'h0, d}, 64'h95);
    for (int k = 0; k < 3; k++) begin
      wr_reg(4'(8 + k), 8'(8'hC7 - k * 53));
      m_en[k*8 +: 8] = 8'(8'hC7 - k * 53);
      chk_side("R6 en");
    end
    for (int k = 0; k < 3; k++) begin
      rd_reg(4'(8 + k), d);
      chk("R6 read", {56'h0, d}, {56'h0, m_en[k*8 +: 8]});
    end

    // R7 status page
    wr_reg(4'h7, 8'hC0);
    for (int k = 0; k < 3; k++) begin
      rd_reg(4'(8 + k), d);
      chk("R7 pend read", {56'h0, d}, {56'h0, pend[k*8 +: 8]});
    end
    for (int k = 0; k < 3; k++) begin
      logic [23:0] e;
      e = '0; e[k*8 +: 8] = 8'(8'h81 >> k) | 8'h10;
      wr_reg(4'(8 + k), e[k*8 +: 8]);
      chk("R7 clr pulse", {40'h0, clr}, {40'h0, e});
      chk_side("R7 side");
      @(posedge clk); #1;
      chk("R7 clr end", {40'h0, clr}, 64'h0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule